// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines and drives a single interrupt output towards a host processor. Each line can be enabled or disabled on its own. The host can raise any line from software. When the controller is idle it chooses one pending line and serves it. Serving a line means two things: the address of that line's handler is copied from a per-line table into a readable vector register, and the output is asserted. The host reads the vector, runs the handler and writes the acknowledge register. Only then does the controller move on to the next pending line.

The output has two forms. It can be a held level of either polarity. It can also be a single pulse of programmable length, which suits hosts that only see edges. A simple 32-bit register bus with a word address reaches every register and every table entry. Reads are combinational from the word address. A write takes effect on the clock edge at which `bus_wr` is high.

The serving sequence is a four-state machine. The states are S_IDLE (nothing served), S_LEVEL (level output asserted), S_PULSE (pulse running) and S_AWAIT (pulse finished, acknowledge still owed). Its transitions are as follows:
- S_IDLE goes to S_LEVEL when the block is enabled, a line is pending and enabled, and edge mode is off.
- S_IDLE goes to S_PULSE under the same conditions with edge mode on.
- S_LEVEL goes to S_IDLE on acknowledge.
- S_PULSE goes to S_AWAIT when the pulse counter runs out.
- S_PULSE goes to S_IDLE on acknowledge.
- S_AWAIT goes to S_IDLE on acknowledge.
- Any state goes to S_IDLE when the block is disabled.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every register and table entry reads 0 and the output sits at its inactive level for polarity 0, which is 1.
- R2: The control register is at byte offset 0x00 and has four fields. Bit 0 enables the block. Bit 1 selects the polarity: 1 means active high, 0 means active low. Bit 2 selects edge mode. Bits 18:3 hold the pulse length. Bits 31:19 ignore writes and read 0.
- R3: Writing to the enable register (0x08) sets mask bit n for every 1 in bit n of the written word. Writing to the disable register (0x0C) clears mask bit n for every 1 in bit n. Zero bits leave the mask unchanged. The mask reads at 0x10, and writes to 0x10 have no effect.
- R4: The raw status register (0x04) reads the OR of the hardware lines and the software-raised bits, whatever the mask holds.
- R5: The vector table starts at byte offset 0x80 and holds one 32-bit read/write entry per line at a 4-byte stride (line n at 0x80+4n). All entries reset to 0.
- R6: When the block is enabled and in S_IDLE, it serves the lowest-numbered line that is both pending and enabled. The output reaches its active level one clock after the line is seen.
- R7: The vector register (0x14) holds the table entry of the line being served. It is captured when the line is selected.
- R8: Any write to the acknowledge register (0x1C) during service returns the block to S_IDLE. The output goes inactive, and the next pending line is served on the following clock. An acknowledge written while idle changes nothing.
- R9: Writing bit n to the software register (0x18) raises line n. That bit clears when line n is acknowledged.
- R10: The active output level follows the polarity bit.
- R11: While disabled, the block serves nothing and holds the output inactive. Disabling it in the middle of service abandons that service.
- R12: In edge mode the output is active for exactly the programmed number of clocks, or for 1 clock if the length is 0. It then stays inactive until the acknowledge, whatever the line does in the meantime.
- R13: Rewriting the served line's table entry during service leaves the vector register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_IRQ | Hardware request lines, active high level |
| bus_word_addr | input | 6 | Word address (byte offset divided by 4) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word_addr |
| irq_out | output | 1 | Interrupt output to the host |

## Verification
The hardest situation to reach is the one in which the controller must ignore a line that is still asserted. This happens in S_AWAIT, after an edge pulse has run out but before the acknowledge. It also happens right after an acknowledge, when a second line is already waiting. The bench holds the request line high across a window several clocks longer than the pulse and counts the active cycles, which must equal the programmed length exactly. In a separate test it drops one of two raised lines just before acknowledging. It also sweeps every line index with varied higher-numbered lines raised together, so that lowest-index selection and the vector captured with it are checked at every position.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BUS_W    = 32;
    localparam int WADDR_W  = 6;
    localparam int IDX_W    = 5;
    localparam int LEN_W    = 16;
    localparam int CTRL_W   = 3 + LEN_W;

    // word addresses (byte offset / 4)
    localparam logic [WADDR_W-1:0] WA_CTRL = 6'h00;
    localparam logic [WADDR_W-1:0] WA_RAW  = 6'h01;
    localparam logic [WADDR_W-1:0] WA_SET  = 6'h02;
    localparam logic [WADDR_W-1:0] WA_CLR  = 6'h03;
    localparam logic [WADDR_W-1:0] WA_MASK = 6'h04;
    localparam logic [WADDR_W-1:0] WA_VEC  = 6'h05;
    localparam logic [WADDR_W-1:0] WA_SOFT = 6'h06;
    localparam logic [WADDR_W-1:0] WA_ACK  = 6'h07;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LEVEL = 2'd1,
        S_PULSE = 2'd2,
        S_AWAIT = 2'd3
    } serve_state_t;

endpackage

// File: rtl/irqc_lowest_pick.sv
module irqc_lowest_pick
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_vec_table.sv
module irqc_vec_table
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [IDX_W-1:0]  sel_idx,
    output logic [BUS_W-1:0]  sel_data
);

    logic [BUS_W-1:0] entry [NUM_IRQ];

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                entry[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
                entry[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data  = '0;
        sel_data = '0;
        if (int'(rd_idx) < NUM_IRQ)
            rd_data = entry[rd_idx];
        if (int'(sel_idx) < NUM_IRQ)
            sel_data = entry[sel_idx];
    end

endmodule

// File: rtl/irqc_serve_fsm.sv
module irqc_serve_fsm
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pol,
    input  logic              edge_mode,
    input  logic [LEN_W-1:0]  pulse_len,
    input  logic              found,
    input  logic [IDX_W-1:0]  pick_idx,
    input  logic [BUS_W-1:0]  pick_vec,
    input  logic              ack_wr,
    output serve_state_t      state,
    output logic [IDX_W-1:0]  serve_idx,
    output logic [BUS_W-1:0]  vec_addr,
    output logic [LEN_W-1:0]  cnt,
    output logic              ack_done,
    output logic              irq_out
);

    serve_state_t nxt;
    logic         take;

    assign take = (state == S_IDLE) && en && found;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (en && found) nxt = edge_mode ? S_PULSE : S_LEVEL;
            S_LEVEL: if (ack_wr) nxt = S_IDLE;
            S_PULSE: begin
                if (ack_wr)        nxt = S_IDLE;
                else if (cnt <= 1) nxt = S_AWAIT;
            end
            S_AWAIT: if (ack_wr) nxt = S_IDLE;
        endcase
        if (!en) nxt = S_IDLE;
    end

    // state register and service context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            serve_idx <= '0;
            vec_addr  <= '0;
            cnt       <= '0;
        end else begin
            state <= nxt;
            if (take) begin
                serve_idx <= pick_idx;
                vec_addr  <= pick_vec;
                cnt       <= (pulse_len == '0) ? LEN_W'(1) : pulse_len;
            end else if (state == S_PULSE && cnt > 1) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ack_done = ack_wr && (state != S_IDLE);
        if (en && (state == S_LEVEL || state == S_PULSE))
            irq_out = pol;
        else
            irq_out = ~pol;
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [5:0]         bus_word_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_out
);

    localparam int TBL_BASE = 32;

    logic [CTRL_W-1:0]  ctrl_q;
    logic [NUM_IRQ-1:0] mask_q;
    logic [NUM_IRQ-1:0] soft_q;
    logic [NUM_IRQ-1:0] pending;
    logic [NUM_IRQ-1:0] soft_clr;

    logic               ctrl_en, ctrl_pol, ctrl_edge;
    logic [LEN_W-1:0]   ctrl_len;

    logic               tbl_sel, tbl_wr, ack_wr, ack_done;
    logic [IDX_W-1:0]   tbl_idx;
    logic [BUS_W-1:0]   tbl_rdata, pick_vec, vec_addr;
    logic               found;
    logic [IDX_W-1:0]   pick_idx, serve_idx;
    logic [LEN_W-1:0]   pulse_cnt;
    serve_state_t       fsm_state;

    function automatic logic [BUS_W-1:0] widen(input logic [NUM_IRQ-1:0] v);
        logic [BUS_W-1:0] r;
        r = '0;
        r[NUM_IRQ-1:0] = v;
        return r;
    endfunction

    assign ctrl_en   = ctrl_q[0];
    assign ctrl_pol  = ctrl_q[1];
    assign ctrl_edge = ctrl_q[2];
    assign ctrl_len  = ctrl_q[CTRL_W-1:3];

    assign tbl_sel = (int'(bus_word_addr) >= TBL_BASE);
    assign tbl_idx = bus_word_addr[IDX_W-1:0];
    assign tbl_wr  = bus_wr && tbl_sel;
    assign ack_wr  = bus_wr && (bus_word_addr == WA_ACK);
    assign pending = irq_in | soft_q;

    always_comb begin
        soft_clr = '0;
        if (ack_done)
            soft_clr[serve_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
            soft_q <= '0;
        end else begin
            if (bus_wr && bus_word_addr == WA_CTRL)
                ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (bus_wr && bus_word_addr == WA_SET)
                mask_q <= mask_q | bus_wdata[NUM_IRQ-1:0];
            if (bus_wr && bus_word_addr == WA_CLR)
                mask_q <= mask_q & ~bus_wdata[NUM_IRQ-1:0];
            soft_q <= (soft_q & ~soft_clr) |
                      ((bus_wr && bus_word_addr == WA_SOFT) ? bus_wdata[NUM_IRQ-1:0] : '0);
        end
    end

    irqc_lowest_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
        .req   (pending & mask_q),
        .found (found),
        .idx   (pick_idx)
    );

    irqc_vec_table #(.NUM_IRQ(NUM_IRQ)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_idx   (tbl_idx),
        .wr_data  (bus_wdata),
        .rd_idx   (tbl_idx),
        .rd_data  (tbl_rdata),
        .sel_idx  (pick_idx),
        .sel_data (pick_vec)
    );

    irqc_serve_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_en),
        .pol       (ctrl_pol),
        .edge_mode (ctrl_edge),
        .pulse_len (ctrl_len),
        .found     (found),
        .pick_idx  (pick_idx),
        .pick_vec  (pick_vec),
        .ack_wr    (ack_wr),
        .state     (fsm_state),
        .serve_idx (serve_idx),
        .vec_addr  (vec_addr),
        .cnt       (pulse_cnt),
        .ack_done  (ack_done),
        .irq_out   (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (tbl_sel) begin
            bus_rdata = tbl_rdata;
        end else begin
            unique case (bus_word_addr)
                WA_CTRL: bus_rdata = BUS_W'(ctrl_q);
                WA_RAW:  bus_rdata = widen(pending);
                WA_MASK: bus_rdata = widen(mask_q);
                WA_VEC:  bus_rdata = vec_addr;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [5:0]         bus_word_addr,
    input  logic               irq_out,
    input  logic               en,
    input  logic               pol,
    input  logic [NUM_IRQ-1:0] mask,
    input  serve_state_t       state,
    input  logic [31:0]        vec,
    input  logic [LEN_W-1:0]   cnt
);

    logic mask_wr, ack_wr;
    assign mask_wr = bus_wr && (bus_word_addr == WA_SET || bus_word_addr == WA_CLR);
    assign ack_wr  = bus_wr && (bus_word_addr == WA_ACK);

    // R3
    mask_only_by_set_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask));

    // R11
    disabled_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> irq_out == ~pol);

    // R11
    disabled_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == S_IDLE);

    // R8
    ack_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && state != S_IDLE) |=> state == S_IDLE);

    // R13
    vector_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(vec));

    // R12
    pulse_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PULSE) |-> cnt != '0);

endmodule

bind irq_vector_ctrl irqc_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_word_addr (bus_word_addr),
    .irq_out       (irq_out),
    .en            (ctrl_en),
    .pol           (ctrl_pol),
    .mask          (mask_q),
    .state         (fsm_state),
    .vec           (vec_addr),
    .cnt           (pulse_cnt)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [5:0]    bus_word_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_vector_ctrl #(.NUM_IRQ(N)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_in        (irq_in),
        .bus_word_addr (bus_word_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq_out       (irq_out)
    );

    function automatic logic [31:0] tval(input int n);
        return 32'hC000_0000 ^ (32'(n) * 32'h0101_0101) ^ 32'(n << 2);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_word_addr = a;
        bus_wdata     = d;
        bus_wr        = 1'b1;
        @(negedge clk);
        bus_wr        = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_word_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pat;
        int cnt;
        int exp_len;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 out", 32'(irq_out), 32'd1);
        rd(6'h00, v); chk("R1 ctrl", v, 0);
        rd(6'h04, v); chk("R1 mask", v, 0);
        rd(6'h01, v); chk("R1 raw", v, 0);
        rd(6'h05, v); chk("R1 vec", v, 0);
        for (int n = 0; n < N; n += 7) begin
            rd(6'(32 + n), v); chk("R1 R5 table reset", v, 0);
        end

        // R2 reserved control bits
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, v); chk("R2 ctrl fields", v, 32'h0007_FFFF);
        wr(6'h00, 32'h0);
        rd(6'h00, v); chk("R2 ctrl clear", v, 0);

        // R3 set/clear mask
        wr(6'h02, 32'h0000_00F0); rd(6'h04, v); chk("R3 set", v, 32'hF0);
        wr(6'h02, 32'h0000_0003); rd(6'h04, v); chk("R3 set accumulate", v, 32'hF3);
        wr(6'h03, 32'h0000_0030); rd(6'h04, v); chk("R3 clear", v, 32'hC3);
        wr(6'h03, 32'h0);         rd(6'h04, v); chk("R3 zero clear", v, 32'hC3);
        wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); chk("R3 mask readonly", v, 32'hC3);

        // R5 table write/read sweep
        for (int n = 0; n < N; n++) wr(6'(32 + n), tval(n));
        for (int n = 0; n < N; n++) begin
            rd(6'(32 + n), v); chk("R5 table", v, tval(n));
        end

        // R4 raw status ignores the mask
        wr(6'h03, 32'hFFFF_FFFF);
        irq_in = 32'h8000_0001;
        rd(6'h01, v); chk("R4 raw unmasked", v, 32'h8000_0001);
        irq_in = '0;
        wr(6'h02, 32'hFFFF_FFFF);

        // enable, active high
        wr(6'h00, 32'h3);
        chk("R10 idle low", 32'(irq_out), 0);

        // R6 R7 sweep of every line with higher lines also raised
        for (int n = 0; n < N; n++) begin
            pat = ((32'h9E37_79B9 * 32'(n + 1)) | (32'h1 << n)) & (32'hFFFF_FFFF << n);
            irq_in = pat;
            @(negedge clk);
            chk("R6 out active", 32'(irq_out), 1);
            rd(6'h05, v); chk("R6 R7 vector lowest", v, tval(n));
            if (n == 7) begin
                wr(6'(32 + 7), 32'h1234_5678);
                rd(6'h05, v); chk("R13 vector held", v, tval(7));
                wr(6'(32 + 7), tval(7));
            end
            irq_in = '0;
            wr(6'h07, 32'h0);
            chk("R8 out after ack", 32'(irq_out), 0);
        end

        // R8 next pending served after ack
        irq_in = (32'h1 << 3) | (32'h1 << 9);
        @(negedge clk);
        rd(6'h05, v); chk("R8 first", v, tval(3));
        irq_in = 32'h1 << 9;
        wr(6'h07, 32'h0);
        chk("R8 gap", 32'(irq_out), 0);
        @(negedge clk);
        chk("R8 next out", 32'(irq_out), 1);
        rd(6'h05, v); chk("R8 next vector", v, tval(9));
        irq_in = '0;
        wr(6'h07, 32'h0);
        wr(6'h07, 32'h0);
        @(negedge clk);
        chk("R8 idle ack out", 32'(irq_out), 0);
        rd(6'h05, v); chk("R8 idle ack vector", v, tval(9));

        // R9 software raise and clear on ack
        wr(6'h06, (32'h1 << 12) | (32'h1 << 20));
        rd(6'h01, v); chk("R9 R4 raw soft", v, (32'h1 << 12) | (32'h1 << 20));
        @(negedge clk);
        chk("R9 out", 32'(irq_out), 1);
        rd(6'h05, v); chk("R9 vector", v, tval(12));
        wr(6'h07, 32'h0);
        rd(6'h01, v); chk("R9 cleared served", v, 32'h1 << 20);
        @(negedge clk);
        rd(6'h05, v); chk("R9 second", v, tval(20));
        wr(6'h07, 32'h0);
        rd(6'h01, v); chk("R9 all cleared", v, 0);

        // R10 active low
        wr(6'h00, 32'h1);
        chk("R10 low idle", 32'(irq_out), 1);
        irq_in = 32'h1 << 2;
        @(negedge clk);
        chk("R10 low active", 32'(irq_out), 0);
        irq_in = '0;
        wr(6'h07, 32'h0);
        chk("R10 low released", 32'(irq_out), 1);

        // R11 disabled
        wr(6'h00, 32'h2);
        irq_in = 32'h1 << 5;
        repeat (3) @(negedge clk);
        chk("R11 disabled high pol", 32'(irq_out), 0);
        rd(6'h05, v); chk("R11 no capture", v, tval(2));
        wr(6'h00, 32'h0);
        chk("R11 disabled low pol", 32'(irq_out), 1);
        wr(6'h00, 32'h3);
        @(negedge clk);
        chk("R11 serve", 32'(irq_out), 1);
        wr(6'h00, 32'h2);
        chk("R11 abandon", 32'(irq_out), 0);
        irq_in = '0;
        wr(6'h00, 32'h3);
        @(negedge clk);
        chk("R11 idle after re-enable", 32'(irq_out), 0);

        // R12 edge pulse lengths
        foreach (pat[k]) begin
            int lens[6] = '{0, 1, 2, 5, 9, 17};
            if (k < 6) begin
                exp_len = (lens[k] == 0) ? 1 : lens[k];
                wr(6'h00, 32'h7 | (32'(lens[k]) << 3));
                irq_in = 32'h1 << 1;
                cnt = 0;
                for (int c = 0; c < exp_len + 5; c++) begin
                    @(negedge clk);
                    if (irq_out) cnt++;
                end
                chk("R12 pulse length", 32'(cnt), 32'(exp_len));
                chk("R12 inactive awaiting ack", 32'(irq_out), 0);
                rd(6'h05, v); chk("R12 vector", v, tval(1));
                irq_in = '0;
                wr(6'h07, 32'h0);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule